// File: doc/BRIEF.md
# Flash Page Program Buffer

This block gathers the data bytes of a serial-flash page-program command into a one-page staging buffer. When the command closes, it commits the staged bytes to a behavioural flash array. A command opens with a start strobe that carries the target address. The low address bits give the first byte offset inside the page, and the high bits select the page. Each data strobe then stores one byte at the running offset. The offset wraps inside the page, so an overlong stream keeps only its last page-worth of bytes.

A chip-select rise closes the command. If at least one byte arrived, the write-enable latch input is set and the target is not protected, the block raises busy for a fixed, parameterised number of clock cycles. At the end of that time it merges the staged bytes into the array and emits a one-cycle completion pulse, which the surrounding logic uses to clear its write-enable latch. Programming can only clear bits. Each staged byte is therefore stored as the AND of the new data and the old cell contents. Offsets that were not sent keep their contents. A combinational read port exposes the array.

Top module: `pgm_page_buf`

## Requirements
- R1: A command that starts at address A with byte offset o = A[7:0] and page p = A[ADDR_W-1:8] stores its k-th data byte (counting from 0) at page p, offset o+k, when fewer than 256 bytes are sent.
- R2: The offset wraps from 255 to 0 within the same page; no byte ever lands in another page.
- R3: When more than 256 bytes are sent, every offset is programmed with the last byte that was sent to it.
- R4: Offsets of the page that received no byte, and all other pages, keep their previous contents.
- R5: A programmed cell becomes the bitwise AND of its old value and the new byte.
- R6: A chip-select rise after a start with no data bytes does not raise busy and changes nothing.
- R7: A chip-select rise with wel_i low, or with protect_i high, does not raise busy and changes nothing.
- R8: An accepted chip-select rise raises busy_o on the next clock edge, and busy_o then stays high for exactly PROG_CYCLES cycles.
- R9: done_o is a single-cycle pulse in the first cycle after busy_o falls, and the new array contents are visible on the read port in that cycle.
- R10: Start, data and chip-select strobes that arrive while busy_o is high are ignored, and no second program follows.
- R11: After reset, busy_o and done_o are 0 and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a program command and captures addr_i |
| addr_i | input | ADDR_W | Command start address (page and byte offset) |
| data_i | input | 8 | Data byte |
| data_valid_i | input | 1 | Strobe for one data byte |
| cs_rise_i | input | 1 | Chip-select rise; closes the command |
| wel_i | input | 1 | Write-enable latch state |
| protect_i | input | 1 | Target page is protected |
| rd_addr_i | input | ADDR_W | Array read address |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | Program completion pulse (clears the write-enable latch) |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The assertions assume the following about the inputs:
- cs_rise_i is a single-cycle strobe and never coincides with data_valid_i.
- wel_i and protect_i are only meaningful in the cycle of the chip-select rise.
- Every command opens with start_i before its data.

The stimulus drives all inputs on the falling clock edge and never overlaps these strobes. It keeps wel_i and protect_i at the values under test only around the closing strobe. Sweeps over start offsets and stream lengths (single byte, short, one page, overrun) compare every array byte with an arithmetic model after each program.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/pgm_collect.sv
module pgm_collect
  import pgm_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_PAGES  = 4,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  byte_t                         data_i,
  input  logic                          valid_i,
  input  logic                          close_i,
  input  logic                          hold_i,
  output logic                          open_o,
  output logic                          got_o,
  output logic [PG_W-1:0]               page_o,
  output logic [PAGE_BYTES-1:0][7:0]    buf_o,
  output logic [PAGE_BYTES-1:0]         mask_o
);
  logic                  open_q, got_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic                  wr_en;

  // a byte coinciding with the closing strobe is dropped
  assign wr_en = open_q && valid_i && !close_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      got_q  <= 1'b0;
      ptr_q  <= '0;
      page_q <= '0;
      mask_q <= '0;
    end else if (start_i && !hold_i) begin
      open_q <= 1'b1;
      got_q  <= 1'b0;
      ptr_q  <= addr_i[OFF_W-1:0];
      page_q <= addr_i[ADDR_W-1:OFF_W];
      mask_q <= '0;
    end else if (open_q && close_i) begin
      open_q <= 1'b0;
    end else if (wr_en) begin
      got_q         <= 1'b1;
      mask_q[ptr_q] <= 1'b1;
      ptr_q         <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en && !(start_i && !hold_i)) buf_q[ptr_q] <= data_i;
  end

  assign open_o = open_q;
  assign got_o  = got_q;
  assign page_o = page_q;
  assign buf_o  = buf_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int PROG_CYCLES = 64,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic busy_o,
  output logic commit_o,
  output logic done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0);
  assign done_o   = done_q;
endmodule

// File: rtl/pgm_array.sv
module pgm_array
  import pgm_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_PAGES  = 4,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W,
  localparam int DEPTH  = PAGE_BYTES * NUM_PAGES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PG_W-1:0]            page_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_i,
  input  logic [PAGE_BYTES-1:0]      mask_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output byte_t                      rd_data_o
);
  byte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= ERASED;
    end else if (commit_i) begin
      // cells can only lose ones
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_i[i])
          mem_q[{page_i, OFF_W'(i)}] <= mem_q[{page_i, OFF_W'(i)}] & buf_i[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pgm_page_buf.sv
module pgm_page_buf
  import pgm_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 64,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  input  logic              cs_rise_i,
  input  logic              wel_i,
  input  logic              protect_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rd_data_o
);
  logic                       open, got, launch, commit, busy;
  logic [PG_W-1:0]            page;
  logic [PAGE_BYTES-1:0][7:0] pbuf;
  logic [PAGE_BYTES-1:0]      mask;

  pgm_collect #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .valid_i (data_valid_i),
    .close_i (cs_rise_i),
    .hold_i  (busy),
    .open_o  (open),
    .got_o   (got),
    .page_o  (page),
    .buf_o   (pbuf),
    .mask_o  (mask)
  );

  assign launch = open && cs_rise_i && got && wel_i && !protect_i && !busy;

  pgm_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .busy_o   (busy),
    .commit_o (commit),
    .done_o   (done_o)
  );

  pgm_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .page_i    (page),
    .buf_i     (pbuf),
    .mask_i    (mask),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/pgm_page_buf_chk.sv
module pgm_page_buf_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic data_valid_i,
  input logic cs_rise_i,
  input logic wel_i,
  input logic protect_i,
  input logic busy_o,
  input logic done_o
);
  int   busy_len;
  logic saw_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len <= 0;
      saw_byte <= 1'b0;
    end else begin
      busy_len <= busy_o ? busy_len + 1 : 0;
      if (start_i && !busy_o) saw_byte <= 1'b0;
      else if (data_valid_i && !busy_o) saw_byte <= 1'b1;
    end
  end

  // R7
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i) && $past(wel_i) && !$past(protect_i));

  // R6
  needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(saw_byte));

  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len == PROG_CYCLES);

  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o);
endmodule

bind pgm_page_buf pgm_page_buf_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .data_valid_i (data_valid_i),
  .cs_rise_i    (cs_rise_i),
  .wel_i        (wel_i),
  .protect_i    (protect_i),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/sim_pgm_page_buf.sv
module sim_pgm_page_buf;
  localparam int PB = 256;
  localparam int NP = 2;
  localparam int PC = 20;
  localparam int AW = 9;
  localparam int DEPTH = PB * NP;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0, data_valid_i = 1'b0, cs_rise_i = 1'b0;
  logic          wel_i = 1'b0, protect_i = 1'b0;
  logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          busy_o, done_o;
  logic [7:0]    rd_data_o;

  logic [7:0] mem_m [DEPTH];
  logic [7:0] buf_m [PB];
  bit         msk_m [PB];
  int n_chk = 0, n_bad = 0;

  pgm_page_buf #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .PROG_CYCLES(PC)) u0 (.*);

  always #4 clk_i = ~clk_i;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 29 + seed * 13) ^ (k >> 2) ^ seed);
  endfunction

  task automatic check_mem(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = AW'(a);
      #0.1;
      chk(rd_data_o === mem_m[a], req, rd_data_o, mem_m[a]);
    end
  endtask

  task automatic issue(input int addr, input int n, input int seed, input bit wel, input bit prot);
    @(negedge clk_i);
    start_i = 1'b1; addr_i = AW'(addr);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      data_valid_i = 1'b1; data_i = pat(k, seed);
      @(negedge clk_i);
    end
    data_valid_i = 1'b0;
    cs_rise_i = 1'b1; wel_i = wel; protect_i = prot;
    @(negedge clk_i);
    cs_rise_i = 1'b0; wel_i = 1'b0; protect_i = 1'b0;
  endtask

  task automatic model(input int addr, input int n, input int seed);
    int pg = addr / PB;
    int off = addr % PB;
    for (int i = 0; i < PB; i++) msk_m[i] = 0;
    for (int k = 0; k < n; k++) begin
      buf_m[(off + k) % PB] = pat(k, seed);
      msk_m[(off + k) % PB] = 1;
    end
    for (int i = 0; i < PB; i++)
      if (msk_m[i]) mem_m[pg * PB + i] = mem_m[pg * PB + i] & buf_m[i];
  endtask

  task automatic finish_run(input int exp_len, input string req);
    int cnt = 0;
    while (busy_o === 1'b1 && cnt < 1000) begin
      cnt++;
      @(negedge clk_i);
    end
    chk(cnt == exp_len, "R8 busy length", cnt, exp_len);
    chk(done_o === 1'b1, "R9 done after busy", done_o, 1);
    rd_addr_i = '0;
    #0.1;
    chk(rd_data_o === mem_m[0], "R9 contents at done", rd_data_o, mem_m[0]);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R9 done single cycle", done_o, 0);
    check_mem(req);
  endtask

  task automatic run_prog(input int addr, input int n, input int seed, input string req);
    issue(addr, n, seed, 1'b1, 1'b0);
    chk(busy_o === 1'b1, "R8 busy rises", busy_o, 1);
    model(addr, n, seed);
    finish_run(PC, req);
  endtask

  task automatic run_ignored(input int addr, input int n, input bit wel, input bit prot, input string req);
    issue(addr, n, 77, wel, prot);
    for (int c = 0; c < 4; c++) begin
      chk(busy_o === 1'b0 && done_o === 1'b0, req, {busy_o, done_o}, 0);
      @(negedge clk_i);
    end
    check_mem(req);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem_m[a] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11
    chk(busy_o === 1'b0, "R11 reset busy", busy_o, 0);
    chk(done_o === 1'b0, "R11 reset done", done_o, 0);
    check_mem("R11 erased after reset");

    run_prog(16'h010, 8, 1, "R1 short stream at offset");
    run_prog(PB + 8'hF8, 20, 2, "R2 wrap within page");
    run_prog(8'h80, 300, 3, "R3 overrun last bytes win");
    run_prog(8'h20, 3, 4, "R4 unsent offsets kept");
    run_prog(PB, 256, 5, "R5 AND with old contents");

    run_ignored(8'h40, 0, 1'b1, 1'b0, "R6 zero bytes no program");
    run_ignored(8'h40, 5, 1'b0, 1'b0, "R7 wel low ignored");
    run_ignored(PB + 8'h40, 5, 1'b1, 1'b1, "R7 protected ignored");

    // R10: strobes during busy
    issue(8'h60, 4, 6, 1'b1, 1'b0);
    model(8'h60, 4, 6);
    start_i = 1'b1; addr_i = AW'(PB + 8'h10);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      data_valid_i = 1'b1; data_i = 8'h00;
      @(negedge clk_i);
    end
    data_valid_i = 1'b0; cs_rise_i = 1'b1; wel_i = 1'b1;
    @(negedge clk_i);
    cs_rise_i = 1'b0; wel_i = 1'b0;
    finish_run(PC - 5, "R10 strobes during busy ignored");
    for (int c = 0; c < 4; c++) begin
      chk(busy_o === 1'b0, "R10 no second program", busy_o, 0);
      @(negedge clk_i);
    end

    // sweep of offsets and lengths
    for (int s = 0; s < 16; s++) begin
      int lens[4] = '{1, 5, 255, 257};
      for (int j = 0; j < 4; j++)
        run_prog((s % NP) * PB + s * 17, lens[j], 40 + s * 4 + j, "R1 R2 R3 R4 R5 sweep");
    end

    report();
    $finish;
  end
endmodule